// File: doc/BRIEF.md
# Removable Media Presence Tracker

This block sits in a storage bridge next to a removable-media socket. It watches the socket's presence pin and keeps the sense status the bridge hands back when the host asks why a command could not complete. While the medium is absent, every query returns a no-media code. When the medium comes back, the first query returns a one-time media-changed code. After that, queries return the all-clear code again.

The active level of the presence pin can be set at run time. Detection as a whole can be switched off, and the medium is then treated as permanently present. The pin is first synchronised and then filtered, so that contact bounce and short glitches never reach the reported status. The command parser that issues the queries drives a one-cycle query strobe. It reads the resulting code and qualifier from registered outputs on the following cycle.

Top module: `media_sense_tracker`

## Requirements
- R1: After reset, `media_present` is 1, `sense_code` and `sense_qual` are 8'h00, and no media-changed report is pending: the first query after reset, with the pin showing presence, returns 8'h00/8'h00.
- R2: While `detect_en` is 0, `media_present` is 1 and every query returns 8'h00/8'h00, whatever the level of the presence pin.
- R3: With `pin_active_high` = 1, a high pin means the medium is present. With `pin_active_high` = 0, a low pin means the medium is present.
- R4: A pin change reaches `media_present` only after the synchronised level has differed from the accepted level for DEBOUNCE_CYCLES consecutive cycles. The change appears SYNC_STAGES+DEBOUNCE_CYCLES clock edges after the pin moves. A deviation lasting DEBOUNCE_CYCLES-1 cycles or less has no effect.
- R5: A query made while the medium is absent returns code 8'h3A with qualifier 8'h00.
- R6: The first query after the medium is accepted as present again returns code 8'h28 with qualifier 8'h00.
- R7: Once the media-changed code has been returned, later queries return 8'h00/8'h00 until the medium is removed again.
- R8: If the medium is removed before a pending media-changed report is read, the pending report is dropped and queries return 8'h3A/8'h00. The next reinsertion yields exactly one 8'h28 report.
- R9: The result of a query appears on `sense_code`/`sense_qual` one clock after `query_stb` is sampled high. It holds there, unchanged by pin activity, until the next query.
- R10: A query sampled in the same cycle that `media_present` first shows reinsertion returns 8'h28 and consumes the report. A query sampled in the first cycle that shows removal returns 8'h3A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presence_pin | input | 1 | Raw, asynchronous presence signal from the socket |
| detect_en | input | 1 | 1 enables presence detection; 0 treats the medium as always present |
| pin_active_high | input | 1 | 1: a high pin means present; 0: a low pin means present |
| query_stb | input | 1 | One-cycle request to latch the current sense status |
| sense_code | output | 8 | Additional sense code from the latest query |
| sense_qual | output | 8 | Additional sense code qualifier from the latest query |
| media_present | output | 1 | Filtered presence after enable and polarity are applied |

## Verification
Two functions can fall in the same clock: the filter accepting a new presence level, and a host query. The bench provokes both orderings. It polls `media_present` on every falling edge and raises `query_stb` in the very cycle the output first shows the new level. That query is then sampled on the same rising edge as the edge-detection register. For reinsertion, the bench expects 8'h28 from that query and 8'h00 from the next one, which proves the report was consumed rather than duplicated or lost. For removal, it expects 8'h3A straight away.

// File: rtl/media_sense_pkg.sv
package media_sense_pkg;

    // Sense codes returned to the host
    localparam logic [7:0] SENSE_ALL_CLEAR = 8'h00;
    localparam logic [7:0] SENSE_MEDIA_CHG = 8'h28;
    localparam logic [7:0] SENSE_NO_MEDIA  = 8'h3A;
    localparam logic [7:0] SENSE_QUAL_NONE = 8'h00;

    // Registered state of the status reporter
    typedef struct packed {
        logic       seen_present;   // presence as sampled last cycle
        logic       change_pending; // reinsertion not yet reported
        logic [7:0] code;
        logic [7:0] qual;
    } report_state_t;

endpackage

// File: rtl/presence_filter.sv
module presence_filter #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 16   // keep larger than SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic active_high,
    output logic level_present
);

    localparam int CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   stable;
    } filt_state_t;

    filt_state_t state_d, state_q;
    logic        sample_present;

    always_comb begin
        state_d        = state_q;
        state_d.sync[0] = pin_raw;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            state_d.sync[i] = state_q.sync[i-1];
        end

        sample_present = active_high ? state_q.sync[SYNC_STAGES-1]
                                     : ~state_q.sync[SYNC_STAGES-1];

        if (sample_present != state_q.stable) begin
            if (state_q.cnt == CNT_LIMIT) begin
                state_d.stable = sample_present;
                state_d.cnt    = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end else begin
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sync   <= '0;
            state_q.cnt    <= '0;
            state_q.stable <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign level_present = state_q.stable;

    // R4: accepted level moves only toward a level the sampled pin was showing
    assert_follow_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.stable != $past(state_q.stable)) |-> $past(sample_present != state_q.stable));

    // R4: a sample that agrees with the accepted level leaves no partial count
    assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_present == state_q.stable) |=> (state_q.cnt == '0));

endmodule

// File: rtl/sense_reporter.sv
module sense_reporter
    import media_sense_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       present,
    input  logic       query,
    output logic [7:0] code,
    output logic [7:0] qual
);

    report_state_t rep_d, rep_q;
    logic          reinserted;
    logic          pending_now;

    always_comb begin
        rep_d       = rep_q;
        reinserted  = present & ~rep_q.seen_present;
        pending_now = rep_q.change_pending | reinserted;

        rep_d.seen_present = present;

        if (query) begin
            rep_d.qual = SENSE_QUAL_NONE;
            if (!present) begin
                rep_d.code = SENSE_NO_MEDIA;
            end else if (pending_now) begin
                rep_d.code = SENSE_MEDIA_CHG;
            end else begin
                rep_d.code = SENSE_ALL_CLEAR;
            end
        end

        if (!present) begin
            rep_d.change_pending = 1'b0;
        end else if (query) begin
            rep_d.change_pending = 1'b0;
        end else begin
            rep_d.change_pending = pending_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q.seen_present   <= 1'b1;
            rep_q.change_pending <= 1'b0;
            rep_q.code           <= SENSE_ALL_CLEAR;
            rep_q.qual           <= SENSE_QUAL_NONE;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign code = rep_q.code;
    assign qual = rep_q.qual;

    assert_no_media_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (query && !present) |=> (code == SENSE_NO_MEDIA && qual == SENSE_QUAL_NONE));

    assert_edge_query_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (query && $rose(present)) |=> (code == SENSE_MEDIA_CHG));

    assert_reported_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (query && present && $past(query && present)) |=> (code == SENSE_ALL_CLEAR));

    assert_drop_on_removal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> !rep_q.change_pending);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !query |=> ($stable(code) && $stable(qual)));

endmodule

// File: rtl/media_sense_tracker.sv
module media_sense_tracker
    import media_sense_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presence_pin,
    input  logic       detect_en,
    input  logic       pin_active_high,
    input  logic       query_stb,
    output logic [7:0] sense_code,
    output logic [7:0] sense_qual,
    output logic       media_present
);

    logic filtered_present;
    logic effective_present;

    presence_filter #(
        .SYNC_STAGES    (SYNC_STAGES),
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_raw      (presence_pin),
        .active_high  (pin_active_high),
        .level_present(filtered_present)
    );

    // Disabled detection forces presence
    assign effective_present = ~detect_en | filtered_present;

    sense_reporter u_reporter (
        .clk    (clk),
        .rst_n  (rst_n),
        .present(effective_present),
        .query  (query_stb),
        .code   (sense_code),
        .qual   (sense_qual)
    );

    assign media_present = effective_present;

    assert_bypass_never_absent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (query_stb && !detect_en) |=> (sense_code != SENSE_NO_MEDIA));

    assert_qual_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sense_qual == SENSE_QUAL_NONE);

endmodule

// File: tb/media_sense_tracker_bench.sv
module media_sense_tracker_bench;

    localparam int SYNC = 2;
    localparam int DEB  = 6;
    localparam int SETTLE = SYNC + DEB + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presence_pin = 1'b1;
    logic       detect_en = 1'b1;
    logic       pin_active_high = 1'b1;
    logic       query_stb = 1'b0;
    logic [7:0] sense_code;
    logic [7:0] sense_qual;
    logic       media_present;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    media_sense_tracker #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DEB)) u_media_sense_tracker (
        .clk(clk), .rst_n(rst_n), .presence_pin(presence_pin), .detect_en(detect_en),
        .pin_active_high(pin_active_high), .query_stb(query_stb),
        .sense_code(sense_code), .sense_qual(sense_qual), .media_present(media_present)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ask(input string req, input logic [7:0] exp_code);
        query_stb = 1'b1;
        step(1);
        query_stb = 1'b0;
        check(sense_code == exp_code, req, sense_code, exp_code);
        check(sense_qual == 8'h00, req, sense_qual, 8'h00);
    endtask

    task automatic t_reset();
        check(media_present == 1'b1, "R1", media_present, 1);
        check(sense_code == 8'h00, "R1", sense_code, 8'h00);
        ask("R1", 8'h00);
    endtask

    task automatic t_debounce();
        presence_pin = 1'b0;
        step(SYNC + DEB - 1);
        check(media_present == 1'b1, "R4", media_present, 1);
        step(1);
        check(media_present == 1'b0, "R4", media_present, 0);
        ask("R5", 8'h3A);
        presence_pin = 1'b1;
        step(DEB - 1);
        presence_pin = 1'b0;
        for (int i = 0; i < SETTLE; i++) begin
            step(1);
            check(media_present == 1'b0, "R4", media_present, 0);
        end
        ask("R5", 8'h3A);
        presence_pin = 1'b1;
        step(SETTLE);
        check(media_present == 1'b1, "R4", media_present, 1);
        ask("R6", 8'h28);
        ask("R7", 8'h00);
        ask("R7", 8'h00);
    endtask

    task automatic t_polarity();
        pin_active_high = 1'b0;
        step(SETTLE);
        check(media_present == 1'b0, "R3", media_present, 0);
        ask("R3", 8'h3A);
        presence_pin = 1'b0;
        step(SETTLE);
        check(media_present == 1'b1, "R3", media_present, 1);
        ask("R3", 8'h28);
        presence_pin = 1'b1;
        pin_active_high = 1'b1;
        step(SETTLE);
        check(media_present == 1'b1, "R3", media_present, 1);
        ask("R3", 8'h00);
    endtask

    task automatic t_bypass();
        detect_en = 1'b0;
        presence_pin = 1'b0;
        step(SETTLE);
        check(media_present == 1'b1, "R2", media_present, 1);
        ask("R2", 8'h00);
        presence_pin = 1'b1;
        step(SETTLE);
        detect_en = 1'b1;
        step(2);
        ask("R2", 8'h00);
    endtask

    task automatic t_early_removal();
        presence_pin = 1'b0;
        step(SETTLE);
        presence_pin = 1'b1;
        step(SETTLE);
        presence_pin = 1'b0;
        step(SETTLE);
        ask("R8", 8'h3A);
        presence_pin = 1'b1;
        step(SETTLE);
        ask("R8", 8'h28);
        ask("R8", 8'h00);
    endtask

    task automatic t_hold();
        ask("R9", 8'h00);
        presence_pin = 1'b0;
        step(SETTLE);
        check(sense_code == 8'h00, "R9", sense_code, 8'h00);
        ask("R9", 8'h3A);
        presence_pin = 1'b1;
        step(SETTLE);
        check(sense_code == 8'h3A, "R9", sense_code, 8'h3A);
        ask("R9", 8'h28);
    endtask

    task automatic t_same_cycle();
        presence_pin = 1'b0;
        step(SETTLE);
        presence_pin = 1'b1;
        for (int i = 0; i < SETTLE && !media_present; i++) step(1);
        check(media_present == 1'b1, "R10", media_present, 1);
        ask("R10", 8'h28);
        ask("R10", 8'h00);
        presence_pin = 1'b0;
        for (int i = 0; i < SETTLE && media_present; i++) step(1);
        check(media_present == 1'b0, "R10", media_present, 0);
        ask("R10", 8'h3A);
        presence_pin = 1'b1;
        step(SETTLE);
        ask("R10", 8'h28);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_debounce();
        t_polarity();
        t_bypass();
        t_early_removal();
        t_hold();
        t_same_cycle();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule